// File: doc/BRIEF.md
# Power-On Memory Scrub Sequencer

After power-up the cells of a parity-protected word memory hold arbitrary values, so both data and check bits are illegal. This sequencer puts every word into a legal state and proves that state before normal instruction execution begins. The address source is the generator that also serves refresh: a linear feedback shift register, extended so that it visits every address once per lap. The sequencer counts the laps of that generator. The lap count selects what happens at each address.

Lap 0 is a settling lap with no memory traffic. Lap 1 writes all ones with checking switched off, although the check bits are still computed and stored. Lap 2 reads each word with checking on and writes all zeros to it on the next cycle. Lap 3 reads each word again with checking on. When the count reaches 4, the sequencer raises start-fetch, provided that no byte failed its check. The low three address bits also drive the eight-entry register set, so every register receives ones and then zeros. The memory is synchronous: read data returns on the cycle after a read is issued.

Top module: `pwron_scrub`

## Requirements
- R1: Within each of laps 1, 2 and 3, the address visits each of the DEPTH words exactly once, zero included. DEPTH is 256 or 512. Every lap starts at the same seed address.
- R2: After synchronous reset is released, the first DEPTH cycles (lap 0) issue no read and no write.
- R3: Lap 1 occupies cycles DEPTH to 2·DEPTH-1. Each of these cycles writes 16'hFFFF, issues no read, and stores check bits computed from the written data.
- R4: Lap 2 occupies cycles 2·DEPTH to 4·DEPTH-1. On even offsets the sequencer reads a word. On the following cycle it writes 16'h0000 to the same address, with computed check bits. The read enable and write enable are never high together.
- R5: Lap 3 occupies cycles 4·DEPTH to 5·DEPTH-1 and reads one word per cycle with no writes.
- R6: Check bit 0 covers data bits 7:0 and check bit 1 covers bits 15:8, with even parity: the stored bit equals the XOR of its byte. A read in lap 2 or 3 is checked one cycle later, when its data returns. A mismatch sets bit i of par_err for byte i. Once set, the bit holds until reset.
- R7: start_fetch rises at cycle 5·DEPTH+1, once the last read has been checked, and then stays high. Any bit set in par_err keeps start_fetch low.
- R8: reg_addr equals mem_addr bits 2:0, and reg_we equals mem_we, on every cycle.
- R9: While rst is high, mem_we, mem_re, start_fetch and par_err are all 0. Releasing rst restarts the whole sequence from lap 0, even part-way through a run.
- R10: Once the lap count reaches 4, no further read or write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | log2(DEPTH) | Word address from the lap generator |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | 16 | Write data |
| mem_wpar | output | 2 | Write check bits, one per byte |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_re |
| mem_rpar | input | 2 | Read check bits, valid with mem_rdata |
| reg_addr | output | 3 | Register-set address |
| reg_we | output | 1 | Register-set write enable |
| par_err | output | 2 | Sticky failed-byte flags |
| start_fetch | output | 1 | Initialisation complete; fetch may begin |

## Verification
The case that is hard to reach from the ports is a word that goes bad between the lap that writes it and the lap that checks it. The sequencer rewrites everything it reads, so an ordinary memory never produces a check failure. The bench therefore models the memory itself. At a chosen cycle boundary it flips one data bit in a stored word: in the high byte just after lap 1 ends, and in the low byte just after lap 2 ends. This shows that the correct byte flag latches, survives the rewrite, and holds start_fetch low. A separate run asserts reset in the middle of lap 2 and confirms that the full five-lap timing starts again from the beginning.

// File: rtl/pwron_scrub.sv
module pwron_scrub #(
  parameter int DEPTH = 256,
  parameter int SEED  = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic [$clog2(DEPTH)-1:0] mem_addr,
  output logic                     mem_we,
  output logic                     mem_re,
  output logic [15:0]              mem_wdata,
  output logic [1:0]               mem_wpar,
  input  logic [15:0]              mem_rdata,
  input  logic [1:0]               mem_rpar,
  output logic [2:0]               reg_addr,
  output logic                     reg_we,
  output logic [1:0]               par_err,
  output logic                     start_fetch
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] TAPS  = (AW == 9) ? AW'(9'h110) : AW'(8'hB8);
  localparam logic [AW-1:0] SEEDV = AW'(SEED);

  logic [AW-1:0] lfsr, lfsr_nx;
  logic [2:0]    lap;
  logic          ph, chk_q, fb, step;
  logic [1:0]    err_q, byte_bad;

  // full-period generator: the zero state is spliced in after the lone-MSB state
  assign fb      = (^(lfsr & TAPS)) ^ (lfsr[AW-2:0] == '0);
  assign lfsr_nx = {lfsr[AW-2:0], fb};

  assign step   = (lap == 3'd0) || (lap == 3'd1) || (lap == 3'd2 && ph) || (lap == 3'd3);
  assign mem_re = (lap == 3'd2 && !ph) || (lap == 3'd3);
  assign mem_we = (lap == 3'd1) || (lap == 3'd2 && ph);

  assign mem_wdata = (lap == 3'd1) ? 16'hFFFF : 16'h0000;
  assign mem_wpar  = {^mem_wdata[15:8], ^mem_wdata[7:0]};
  assign mem_addr  = lfsr;
  assign reg_addr  = lfsr[2:0];
  assign reg_we    = mem_we;

  assign byte_bad = {^{mem_rdata[15:8], mem_rpar[1]}, ^{mem_rdata[7:0], mem_rpar[0]}};

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr  <= SEEDV;
      lap   <= 3'd0;
      ph    <= 1'b0;
      chk_q <= 1'b0;
      err_q <= 2'b00;
    end else begin
      chk_q <= mem_re;
      if (chk_q) err_q <= err_q | byte_bad;
      if (lap == 3'd2) ph <= ~ph;
      if (step) begin
        lfsr <= lfsr_nx;
        if (lfsr_nx == SEEDV) lap <= lap + 3'd1;
      end
    end
  end

  assign par_err     = err_q;
  assign start_fetch = (lap == 3'd4) && !chk_q && (err_q == 2'b00);
endmodule

module pwron_scrub_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic [15:0]   mem_wdata,
  input logic [1:0]    par_err,
  input logic          start_fetch
);
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  p_write_value_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == 16'hFFFF || mem_wdata == 16'h0000));

  p_zero_after_read_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_wdata == 16'h0000) |-> ($past(mem_re) && $past(mem_addr) == mem_addr));

  p_err_lo_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    par_err[0] |=> par_err[0]);

  p_err_hi_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    par_err[1] |=> par_err[1]);

  p_fetch_clean_r7: assert property (@(posedge clk) disable iff (rst)
    start_fetch |-> (par_err == 2'b00));

  p_fetch_holds_r7: assert property (@(posedge clk) disable iff (rst)
    start_fetch |=> start_fetch);

  p_fetch_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    start_fetch |-> (!mem_we && !mem_re));
endmodule

bind pwron_scrub pwron_scrub_chk #(.AW($clog2(DEPTH))) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
  .mem_wdata(mem_wdata), .par_err(par_err), .start_fetch(start_fetch)
);

// File: tb/tb_pwron_scrub.sv
`timescale 1ns/1ps
module tb_pwron_scrub;
  localparam int D  = 256;
  localparam int AW = $clog2(D);

  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic [AW-1:0] mem_addr;
  logic mem_we, mem_re, reg_we, start_fetch;
  logic [15:0] mem_wdata, mem_rdata;
  logic [1:0] mem_wpar, mem_rpar, par_err;
  logic [2:0] reg_addr;

  pwron_scrub #(.DEPTH(D)) dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_wpar(mem_wpar), .mem_rdata(mem_rdata), .mem_rpar(mem_rpar),
    .reg_addr(reg_addr), .reg_we(reg_we), .par_err(par_err), .start_fetch(start_fetch)
  );

  logic [15:0] mem_d [D];
  logic [1:0]  mem_p [D];
  logic [15:0] rdq = 16'h0;
  logic [1:0]  rpq = 2'b0;
  assign mem_rdata = rdq;
  assign mem_rpar  = rpq;

  int n = 1;
  int total = 0, bad = 0;
  logic [1:0] merr = 2'b00;
  bit seen [4][D];
  logic [AW-1:0] prev_a = '0;
  bit inj_on = 0;
  int inj_n = 0, inj_a = 0;
  logic [15:0] inj_m = 16'h0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // 0 idle, 1 write ones, 2 read, 3 write zeros
  function automatic int kind(int c);
    if (c < D) return 0;
    if (c < 2*D) return 1;
    if (c < 4*D) return ((c - 2*D) % 2 == 0) ? 2 : 3;
    if (c < 5*D) return 2;
    return 0;
  endfunction

  function automatic int lapof(int c);
    if (c < D) return 0;
    if (c < 2*D) return 1;
    if (c < 4*D) return 2;
    if (c < 5*D) return 3;
    return 4;
  endfunction

  function automatic string tagof(int c);
    case (lapof(c))
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R10";
    endcase
  endfunction

  // memory model: injection, then read capture, then write
  always @(posedge clk) begin
    if (inj_on && n == inj_n) mem_d[inj_a] = mem_d[inj_a] ^ inj_m;
    if (mem_re) begin rdq <= mem_d[mem_addr]; rpq <= mem_p[mem_addr]; end
    if (mem_we) begin mem_d[mem_addr] = mem_wdata; mem_p[mem_addr] = mem_wpar; end
  end

  // reference model, compared every cycle
  always @(negedge clk) begin
    if (rst) begin
      chk(!mem_we && !mem_re && !start_fetch && par_err == 2'b00, "R9", "reset outputs",
          {mem_we, mem_re, start_fetch, par_err}, 0);
      n = 1;
      merr = 2'b00;
      for (int p = 0; p < 4; p++) for (int a = 0; a < D; a++) seen[p][a] = 0;
    end else begin
      int k, p;
      string t;
      k = kind(n); p = lapof(n); t = tagof(n);
      chk(mem_we == (k == 1 || k == 3), t, "mem_we", mem_we, (k == 1 || k == 3));
      chk(mem_re == (k == 2), t, "mem_re", mem_re, (k == 2));
      if (k == 1 || k == 3) begin
        logic [15:0] ew;
        ew = (k == 1) ? 16'hFFFF : 16'h0000;
        chk(mem_wdata == ew, t, "write data", mem_wdata, ew);
        chk(mem_wpar == {^ew[15:8], ^ew[7:0]}, t, "write check bits", mem_wpar, {^ew[15:8], ^ew[7:0]});
      end
      chk(reg_we == mem_we && reg_addr == mem_addr[2:0], "R8", "register port",
          {reg_we, reg_addr}, {mem_we, mem_addr[2:0]});
      chk(start_fetch == (n >= 5*D + 1 && merr == 2'b00), "R7", "start_fetch",
          start_fetch, (n >= 5*D + 1 && merr == 2'b00));
      chk(par_err == merr, "R6", "par_err", par_err, merr);
      if (k == 1 || k == 2) begin
        chk(!seen[p][mem_addr], "R1", "address revisited in lap", mem_addr, 0);
        seen[p][mem_addr] = 1;
      end
      if (k == 3) chk(mem_addr == prev_a, "R4", "zero write address", mem_addr, prev_a);
      prev_a = mem_addr;
      if (n == 2*D || n == 4*D || n == 5*D) begin
        int cnt, pp;
        cnt = 0; pp = lapof(n - 1);
        for (int a = 0; a < D; a++) cnt += seen[pp][a];
        chk(cnt == D, "R1", "distinct addresses in lap", cnt, D);
      end
      if (kind(n - 1) == 2)
        merr = merr | {^{mem_rdata[15:8], mem_rpar[1]}, ^{mem_rdata[7:0], mem_rpar[0]}};
      n = n + 1;
    end
  end

  task automatic go();
    @(negedge clk); #1 rst = 0;
  endtask

  task automatic run_to(int m);
    while (n < m) @(negedge clk);
  endtask

  task automatic hit_reset();
    @(negedge clk); #1 rst = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < D; i++) begin
      mem_d[i] = 16'(i * 40503);
      mem_p[i] = 2'(i);
    end
    repeat (3) @(negedge clk);
    // reset in mid lap 2, then a clean full run
    go();
    run_to(3*D);
    hit_reset();
    go();
    run_to(5*D + 20);
    chk(start_fetch == 1'b1, "R7", "clean run ready", start_fetch, 1);
    chk(par_err == 2'b00, "R6", "clean run flags", par_err, 0);
    // high byte corrupted after lap 1
    hit_reset();
    inj_on = 1; inj_n = 2*D + 1; inj_a = 5; inj_m = 16'h1000;
    go();
    run_to(5*D + 20);
    chk(par_err == 2'b10, "R6", "high byte fault flag", par_err, 2'b10);
    chk(start_fetch == 1'b0, "R7", "fault blocks ready", start_fetch, 0);
    // low byte corrupted after lap 2
    hit_reset();
    inj_n = 4*D + 1; inj_a = 9; inj_m = 16'h0008;
    go();
    run_to(5*D + 20);
    chk(par_err == 2'b01, "R6", "low byte fault flag", par_err, 2'b01);
    chk(start_fetch == 1'b0, "R7", "fault blocks ready", start_fetch, 0);
    inj_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end act=%0d exp=%0d", n, 5*D);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule